// File: doc/BRIEF.md
# Network Controller Control/Status Register Block

This block is the host-visible register file of a descriptor-driven Ethernet controller. A host bus writes and reads 16-bit words at a small set of offsets. One word is the control/status register, which combines the control bits (receive enable, controller reset, interrupt enable, and two loopback controls) with the status flags (non-existent memory, transmit and receive list invalid, transmit done, receive done). The other words hold an interrupt vector and the base addresses of the receive and transmit descriptor lists.

The DMA engines and the MAC sit outside this block. They report events through single-cycle set strobes. They take the list base addresses, the restart strobes, the controller-reset pulse and a level interrupt request from its outputs. A list base address is written in two halves. The low half is only staged. Writing the high half loads the full 32-bit address in one step. If that list was invalid, the same write also clears the invalid flag and sends the matching engine a one-cycle restart strobe. The controller reset is taken on the release of the reset bit and not when it is set.

Top module: `netctl_csr`

## Requirements
- R1: After a synchronous active-low reset, the control/status word reads 0x0030 (both list-invalid flags set, everything else clear). The vector and both list addresses read zero. `irq`, `soft_reset` and both restart strobes are low.
- R2: A write to offset 0 loads receive enable (bit 0), the reset bit (bit 1), interrupt enable (bit 6), internal-loopback disable (bit 8) and external-loopback enable (bit 9). Each of these bits reads back at the same position and drives its output port from the next cycle. Bits 3 and 10 to 14 always read 0.
- R3: `soft_reset` is high for exactly one cycle, in the cycle after an offset-0 write that finds the reset bit set and writes bit 1 as 0. Setting the reset bit, or writing it as 0 while it is already clear, gives no pulse.
- R4: Transmit done (bit 7) and receive done (bit 15) are set by `set_tx_done` and `set_rx_done`. Writing a 1 to either bit at offset 0 clears it. Writing a 0 leaves it unchanged.
- R5: Non-existent memory (bit 2) is set by `set_nxm` and is cleared by writing a 1 to bit 2 at offset 0. Writing a 0 leaves it unchanged.
- R6: When a set strobe and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when interrupt enable is set and at least one of transmit done or receive done is set. Non-existent memory does not raise `irq`.
- R8: Offsets 2/3 are the receive list address low/high and offsets 4/5 the transmit list address low/high. A low write only stages its value, and the staged value reads back at the low offset. A high write loads {high, staged low} onto the list address output. The output changes on no other write.
- R9: A high-half write to a list whose invalid flag is set clears the flag and pulses that list's restart strobe for one cycle, in the next cycle. A high-half write to a valid list updates the address and gives no pulse.
- R10: Transmit list invalid (bit 4) and receive list invalid (bit 5) are set only by `set_tx_invalid` and `set_rx_invalid`. Offset-0 writes have no effect on them. A set strobe in the same cycle as a high-half write leaves the flag set.
- R11: Offset 1 holds the interrupt vector. It is written by the host, read back at offset 1 and driven on `vector`. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write offset |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read offset |
| rd_data | output | DATA_W | Read data (combinational from rd_addr) |
| set_nxm | input | 1 | Engine strobe: non-existent memory |
| set_tx_done | input | 1 | Engine strobe: transmit finished |
| set_rx_done | input | 1 | Engine strobe: receive finished |
| set_tx_invalid | input | 1 | Engine strobe: transmit list exhausted |
| set_rx_invalid | input | 1 | Engine strobe: receive list exhausted |
| rx_enable | output | 1 | Receiver enable |
| int_loop_off | output | 1 | Internal loopback disable |
| ext_loop_on | output | 1 | External loopback enable |
| soft_reset | output | 1 | One-cycle controller reset pulse |
| irq | output | 1 | Level interrupt request |
| vector | output | DATA_W | Interrupt vector |
| rx_list_addr | output | 2*DATA_W | Committed receive list address |
| tx_list_addr | output | 2*DATA_W | Committed transmit list address |
| rx_restart | output | 1 | One-cycle receive engine restart |
| tx_restart | output | 1 | One-cycle transmit engine restart |

## Verification
The main stimulus is a long random mix of host writes and engine strobes. The reset bit is toggled often, so set-then-release pairs show up alongside repeated releases. Set strobes sometimes land in the same cycle as clearing writes. High-half writes arrive with the list both valid and invalid. This separates write-one-to-clear behaviour from plain writes, set priority from clear priority, and restarts gated by the invalid flag from restarts on every high write. Directed cases cover the reset state, a low write alone (which must not move the address), writes of zero to the flags, attempts to write the invalid bits, and readback of the vector and the staged halves.

// File: rtl/netctl_csr_pkg.sv
// Package: register offsets and field positions shared by the register
// block, its checker and its bench. Field positions are fixed by the
// host software contract and assume a 16-bit data word.
package netctl_csr_pkg;
    localparam int CSR_W      = 16;
    localparam int OFF_CSR    = 0;
    localparam int OFF_VEC    = 1;
    localparam int OFF_RXLO   = 2;
    localparam int OFF_RXHI   = 3;
    localparam int OFF_TXLO   = 4;
    localparam int OFF_TXHI   = 5;
    localparam int B_RXEN     = 0;
    localparam int B_RST      = 1;
    localparam int B_NXM      = 2;
    localparam int B_TXINV    = 4;
    localparam int B_RXINV    = 5;
    localparam int B_IE       = 6;
    localparam int B_TXDONE   = 7;
    localparam int B_ILOOP    = 8;
    localparam int B_ELOOP    = 9;
    localparam int B_RXDONE   = 15;
    // Indices into the event-flag bank
    localparam int EV_NXM     = 0;
    localparam int EV_TX      = 1;
    localparam int EV_RX      = 2;
    localparam int N_EV       = 3;
    // Indices into the list-invalid bank
    localparam int LI_TX      = 0;
    localparam int LI_RX      = 1;
    localparam int N_LI       = 2;
endpackage

// File: rtl/netctl_ctrl_reg.sv
// Module: control bits of the control/status word plus the reset-release
// detector. Assumes wr_csr is a one-cycle strobe qualified by offset.
// The reset pulse is registered, so it appears the cycle after the
// write that clears a previously set reset bit.
module netctl_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_csr,
    input  logic d_rxen,
    input  logic d_rst,
    input  logic d_ie,
    input  logic d_iloop,
    input  logic d_eloop,
    output logic rx_en,
    output logic rst_bit,
    output logic int_en,
    output logic iloop_off,
    output logic eloop_on,
    output logic soft_reset
);
    // Control bit storage, loaded on every control/status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en     <= 1'b0;
            rst_bit   <= 1'b0;
            int_en    <= 1'b0;
            iloop_off <= 1'b0;
            eloop_on  <= 1'b0;
        end else if (wr_csr) begin
            rx_en     <= d_rxen;
            rst_bit   <= d_rst;
            int_en    <= d_ie;
            iloop_off <= d_iloop;
            eloop_on  <= d_eloop;
        end
    end

    // Reset pulse: fires once on the falling edge of the stored reset bit
    always_ff @(posedge clk) begin
        if (!rst_n) soft_reset <= 1'b0;
        else        soft_reset <= wr_csr & rst_bit & ~d_rst;
    end
endmodule

// File: rtl/netctl_flag_bank.sv
// Module: a bank of sticky flags, each set by a strobe and cleared by a
// clear request; a set in the same cycle as a clear wins. RST_VAL gives
// each flag's value after reset.
module netctl_flag_bank #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag with set priority
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= RST_VAL[i];
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/netctl_list_addr.sv
// Module: one descriptor-list base address written as two halves. The
// low half is staged; the high half commits the whole address and, if
// the list was invalid, raises a registered one-cycle restart strobe.
module netctl_list_addr #(
    parameter int HALF_W = 16,
    localparam int ADDR_FULL = 2 * HALF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [HALF_W-1:0]    wdata,
    input  logic                 invalid,
    output logic [HALF_W-1:0]    stage_lo,
    output logic [ADDR_FULL-1:0] addr,
    output logic                 restart
);
    // Low-half staging register
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_lo <= '0;
        else if (wr_lo) stage_lo <= wdata;
    end

    // Commit of the full address on the high-half write
    always_ff @(posedge clk) begin
        if (!rst_n)     addr <= '0;
        else if (wr_hi) addr <= {wdata, stage_lo};
    end

    // Restart strobe, only when the list had gone invalid
    always_ff @(posedge clk) begin
        if (!rst_n) restart <= 1'b0;
        else        restart <= wr_hi & invalid;
    end
endmodule

// File: rtl/netctl_csr.sv
// Module: top of the controller register block. Decodes host writes,
// holds the vector, instantiates the control bits, the event and
// list-invalid flag banks and one address register per list, and
// assembles the read mux and the interrupt request. Assumes
// DATA_W = 16, matching the fixed field positions in the package.
module netctl_csr
    import netctl_csr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = CSR_W,
    localparam int LADDR_W = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               set_nxm,
    input  logic               set_tx_done,
    input  logic               set_rx_done,
    input  logic               set_tx_invalid,
    input  logic               set_rx_invalid,
    output logic               rx_enable,
    output logic               int_loop_off,
    output logic               ext_loop_on,
    output logic               soft_reset,
    output logic               irq,
    output logic [DATA_W-1:0]  vector,
    output logic [LADDR_W-1:0] rx_list_addr,
    output logic [LADDR_W-1:0] tx_list_addr,
    output logic               rx_restart,
    output logic               tx_restart
);
    logic              wr_csr, wr_vec, wr_rxlo, wr_rxhi, wr_txlo, wr_txhi;
    logic              rst_bit, int_en;
    logic [N_EV-1:0]   evt_set, evt_clr, evt_flags;
    logic [N_LI-1:0]   inv_set, inv_clr, inv_flags;
    logic [DATA_W-1:0] rx_stage, tx_stage, csr_word;

    // Write decode by offset
    always_comb begin
        wr_csr  = wr_en && (wr_addr == ADDR_W'(OFF_CSR));
        wr_vec  = wr_en && (wr_addr == ADDR_W'(OFF_VEC));
        wr_rxlo = wr_en && (wr_addr == ADDR_W'(OFF_RXLO));
        wr_rxhi = wr_en && (wr_addr == ADDR_W'(OFF_RXHI));
        wr_txlo = wr_en && (wr_addr == ADDR_W'(OFF_TXLO));
        wr_txhi = wr_en && (wr_addr == ADDR_W'(OFF_TXHI));
    end

    // Interrupt vector register
    always_ff @(posedge clk) begin
        if (!rst_n)      vector <= '0;
        else if (wr_vec) vector <= wr_data;
    end

    netctl_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_csr     (wr_csr),
        .d_rxen     (wr_data[B_RXEN]),
        .d_rst      (wr_data[B_RST]),
        .d_ie       (wr_data[B_IE]),
        .d_iloop    (wr_data[B_ILOOP]),
        .d_eloop    (wr_data[B_ELOOP]),
        .rx_en      (rx_enable),
        .rst_bit    (rst_bit),
        .int_en     (int_en),
        .iloop_off  (int_loop_off),
        .eloop_on   (ext_loop_on),
        .soft_reset (soft_reset)
    );

    // Event flag set/clear sources: engine strobes and write-one-to-clear
    always_comb begin
        evt_set[EV_NXM] = set_nxm;
        evt_set[EV_TX]  = set_tx_done;
        evt_set[EV_RX]  = set_rx_done;
        evt_clr[EV_NXM] = wr_csr & wr_data[B_NXM];
        evt_clr[EV_TX]  = wr_csr & wr_data[B_TXDONE];
        evt_clr[EV_RX]  = wr_csr & wr_data[B_RXDONE];
    end

    netctl_flag_bank #(.N(N_EV), .RST_VAL('0)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_set),
        .clr   (evt_clr),
        .flags (evt_flags)
    );

    // List-invalid sources: engine strobes set, high-half commits clear
    always_comb begin
        inv_set[LI_TX] = set_tx_invalid;
        inv_set[LI_RX] = set_rx_invalid;
        inv_clr[LI_TX] = wr_txhi;
        inv_clr[LI_RX] = wr_rxhi;
    end

    netctl_flag_bank #(.N(N_LI), .RST_VAL({N_LI{1'b1}})) u_inv (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (inv_set),
        .clr   (inv_clr),
        .flags (inv_flags)
    );

    netctl_list_addr #(.HALF_W(DATA_W)) u_rxl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_rxlo),
        .wr_hi    (wr_rxhi),
        .wdata    (wr_data),
        .invalid  (inv_flags[LI_RX]),
        .stage_lo (rx_stage),
        .addr     (rx_list_addr),
        .restart  (rx_restart)
    );

    netctl_list_addr #(.HALF_W(DATA_W)) u_txl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_txlo),
        .wr_hi    (wr_txhi),
        .wdata    (wr_data),
        .invalid  (inv_flags[LI_TX]),
        .stage_lo (tx_stage),
        .addr     (tx_list_addr),
        .restart  (tx_restart)
    );

    // Assemble the control/status word from its owners
    always_comb begin
        csr_word           = '0;
        csr_word[B_RXEN]   = rx_enable;
        csr_word[B_RST]    = rst_bit;
        csr_word[B_NXM]    = evt_flags[EV_NXM];
        csr_word[B_TXINV]  = inv_flags[LI_TX];
        csr_word[B_RXINV]  = inv_flags[LI_RX];
        csr_word[B_IE]     = int_en;
        csr_word[B_TXDONE] = evt_flags[EV_TX];
        csr_word[B_ILOOP]  = int_loop_off;
        csr_word[B_ELOOP]  = ext_loop_on;
        csr_word[B_RXDONE] = evt_flags[EV_RX];
    end

    // Host read mux
    always_comb begin
        case (rd_addr)
            ADDR_W'(OFF_CSR):  rd_data = csr_word;
            ADDR_W'(OFF_VEC):  rd_data = vector;
            ADDR_W'(OFF_RXLO): rd_data = rx_stage;
            ADDR_W'(OFF_RXHI): rd_data = rx_list_addr[LADDR_W-1:DATA_W];
            ADDR_W'(OFF_TXLO): rd_data = tx_stage;
            ADDR_W'(OFF_TXHI): rd_data = tx_list_addr[LADDR_W-1:DATA_W];
            default:           rd_data = '0;
        endcase
    end

    // Level interrupt from the done flags, gated by interrupt enable
    always_comb irq = int_en & (evt_flags[EV_TX] | evt_flags[EV_RX]);
endmodule

// File: rtl/netctl_csr_checker.sv
// Module: assertion checker bound into netctl_csr. Observes host
// writes, engine strobes and the flag banks, and checks the timing of
// pulses, the interrupt gating and the address commit rule.
module netctl_csr_checker
    import netctl_csr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic                  wr_rst_bit,
    input logic                  set_nxm,
    input logic                  set_tx_done,
    input logic                  set_tx_invalid,
    input logic                  int_en,
    input logic [N_EV-1:0]       evt_flags,
    input logic [N_LI-1:0]       inv_flags,
    input logic                  irq,
    input logic                  soft_reset,
    input logic                  rx_restart,
    input logic [2*DATA_W-1:0]   rx_list_addr
);
    p_rst_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> $past(wr_en && wr_addr == ADDR_W'(OFF_CSR) && !wr_rst_bit));

    p_txdone_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx_done |=> evt_flags[EV_TX]);

    p_nxm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_nxm |=> evt_flags[EV_NXM]);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_flags[EV_TX] || evt_flags[EV_RX]));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_W'(OFF_RXHI)) |=> $stable(rx_list_addr));

    p_restart_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_restart |-> $past(wr_en && wr_addr == ADDR_W'(OFF_RXHI) && inv_flags[LI_RX]));

    p_inv_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx_invalid |=> inv_flags[LI_TX]);
endmodule

bind netctl_csr netctl_csr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_rst_bit     (wr_data[1]),
    .set_nxm        (set_nxm),
    .set_tx_done    (set_tx_done),
    .set_tx_invalid (set_tx_invalid),
    .int_en         (int_en),
    .evt_flags      (evt_flags),
    .inv_flags      (inv_flags),
    .irq            (irq),
    .soft_reset     (soft_reset),
    .rx_restart     (rx_restart),
    .rx_list_addr   (rx_list_addr)
);

// File: tb/sim_netctl_csr.sv
// Bench: random host writes and engine strobes mixed with directed
// corner cases, checked against a reference model kept in the bench.
module sim_netctl_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        set_nxm = 0, set_tx_done = 0, set_rx_done = 0;
    logic        set_tx_invalid = 0, set_rx_invalid = 0;
    logic        rx_enable, int_loop_off, ext_loop_on, soft_reset, irq;
    logic [15:0] vector;
    logic [31:0] rx_list_addr, tx_list_addr;
    logic        rx_restart, tx_restart;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state
    bit m_rxen, m_rstb, m_ie, m_ilo, m_elo, m_nxm, m_tx, m_rx, m_txinv, m_rxinv;
    bit e_srst, e_rxrs, e_txrs;
    logic [15:0] m_vec, m_rxst, m_txst;
    logic [31:0] m_rxa, m_txa;

    always #4 clk = ~clk;

    netctl_csr u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .set_nxm(set_nxm), .set_tx_done(set_tx_done), .set_rx_done(set_rx_done),
        .set_tx_invalid(set_tx_invalid), .set_rx_invalid(set_rx_invalid),
        .rx_enable(rx_enable), .int_loop_off(int_loop_off), .ext_loop_on(ext_loop_on),
        .soft_reset(soft_reset), .irq(irq), .vector(vector),
        .rx_list_addr(rx_list_addr), .tx_list_addr(tx_list_addr),
        .rx_restart(rx_restart), .tx_restart(tx_restart)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_csr();
        return {m_rx, 5'b0, m_elo, m_ilo, m_tx, m_ie, m_rxinv, m_txinv,
                1'b0, m_nxm, m_rstb, m_rxen};
    endfunction

    function automatic bit exp_irq();
        return m_ie & (m_tx | m_rx);
    endfunction

    task automatic model_reset();
        {m_rxen, m_rstb, m_ie, m_ilo, m_elo, m_nxm, m_tx, m_rx} = '0;
        m_txinv = 1; m_rxinv = 1;
        {e_srst, e_rxrs, e_txrs} = '0;
        m_vec = '0; m_rxst = '0; m_txst = '0; m_rxa = '0; m_txa = '0;
    endtask

    // One cycle: drive at negedge, update model at posedge, check after it.
    // s = {rx_inv, tx_inv, rx_done, tx_done, nxm}
    task automatic step(input bit wr, input logic [2:0] a, input logic [15:0] d,
                        input logic [4:0] s);
        bit wcsr, rxhi, txhi, race;
        @(negedge clk);
        wr_en = wr; wr_addr = a; wr_data = d; rd_addr = 3'd0;
        {set_rx_invalid, set_tx_invalid, set_rx_done, set_tx_done, set_nxm} = s;
        @(posedge clk);
        wcsr = wr && a == 3'd0;
        rxhi = wr && a == 3'd3;
        txhi = wr && a == 3'd5;
        race = wcsr && ((s[0] && d[2]) || (s[1] && d[7]) || (s[2] && d[15]));
        e_srst = wcsr && m_rstb && !d[1];
        if (wcsr) begin
            m_rxen = d[0]; m_rstb = d[1]; m_ie = d[6]; m_ilo = d[8]; m_elo = d[9];
        end
        m_nxm = s[0] | (m_nxm & ~(wcsr & d[2]));
        m_tx  = s[1] | (m_tx  & ~(wcsr & d[7]));
        m_rx  = s[2] | (m_rx  & ~(wcsr & d[15]));
        e_rxrs = rxhi && m_rxinv;
        e_txrs = txhi && m_txinv;
        m_rxinv = s[4] | (m_rxinv & ~rxhi);
        m_txinv = s[3] | (m_txinv & ~txhi);
        if (wr && a == 3'd1) m_vec = d;
        if (wr && a == 3'd2) m_rxst = d;
        if (rxhi) m_rxa = {d, m_rxst};
        if (wr && a == 3'd4) m_txst = d;
        if (txhi) m_txa = {d, m_txst};
        #1;
        chk("R2 control bits", {rd_data[9:8], rd_data[6], rd_data[1:0], rd_data[3],
                                rd_data[14:10], rx_enable, int_loop_off, ext_loop_on},
            {m_elo, m_ilo, m_ie, m_rstb, m_rxen, 1'b0, 5'b0, m_rxen, m_ilo, m_elo});
        chk(race ? "R6 set beats clear" : "R4 done flags",
            {rd_data[15], rd_data[7], rd_data[2]}, {m_rx, m_tx, m_nxm});
        chk("R5 nxm", rd_data[2], m_nxm);
        chk("R10 invalid flags", rd_data[5:4], {m_rxinv, m_txinv});
        chk("R3 reset pulse", soft_reset, e_srst);
        chk("R7 irq", irq, exp_irq());
        chk("R9 restarts", {rx_restart, tx_restart}, {e_rxrs, e_txrs});
        chk("R8 list addrs rx", rx_list_addr, m_rxa);
        chk("R8 list addrs tx", tx_list_addr, m_txa);
        chk("R11 vector", vector, m_vec);
    endtask

    task automatic idle();
        step(0, 3'd0, 16'h0, 5'b0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd7331);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 csr", rd_data, 16'h0030);
        chk("R1 outputs", {irq, soft_reset, rx_restart, tx_restart}, 4'b0);
        chk("R1 addrs", {rx_list_addr, tx_list_addr, vector}, '0);

        // R3: set then release; repeated release gives nothing
        step(1, 3'd0, 16'h0002, 5'b0);
        chk("R3 no pulse on set", soft_reset, 1'b0);
        step(1, 3'd0, 16'h0000, 5'b0);
        chk("R3 pulse on release", soft_reset, 1'b1);
        step(1, 3'd0, 16'h0000, 5'b0);
        chk("R3 single pulse", soft_reset, 1'b0);

        // R4/R7: done flags, zero writes ignored, irq gating
        step(0, 3'd0, 16'h0, 5'b00110);
        chk("R7 irq off without enable", irq, 1'b0);
        step(1, 3'd0, 16'h0040, 5'b0);
        chk("R4 zero write keeps flags", {rd_data[15], rd_data[7]}, 2'b11);
        chk("R7 irq on", irq, 1'b1);
        step(1, 3'd0, 16'h0080 | 16'h0040, 5'b0);
        chk("R4 clear tx only", {rd_data[15], rd_data[7]}, 2'b10);
        step(1, 3'd0, 16'h8040, 5'b0);
        chk("R7 irq drops", irq, 1'b0);
        // R5: nxm alone does not interrupt
        step(0, 3'd0, 16'h0, 5'b00001);
        chk("R5 nxm no irq", irq, 1'b0);
        // R6: set and clear in the same cycle
        step(1, 3'd0, 16'h8084, 5'b00111);
        chk("R6 set wins", {rd_data[15], rd_data[7], rd_data[2]}, 3'b111);
        step(1, 3'd0, 16'h8084, 5'b0);

        // R10: invalid bits not writable by the host
        step(1, 3'd0, 16'h0000, 5'b0);
        chk("R10 write zero keeps invalid", rd_data[5:4], 2'b11);
        step(1, 3'd0, 16'h0030, 5'b0);
        chk("R10 write one keeps invalid", rd_data[5:4], 2'b11);

        // R8/R9: low alone stages, high commits and restarts
        step(1, 3'd2, 16'hbeef, 5'b0);
        chk("R8 low write no commit", rx_list_addr, 32'h0);
        @(negedge clk); rd_addr = 3'd2; #1;
        chk("R8 staged readback", rd_data, 16'hbeef);
        step(1, 3'd3, 16'h1234, 5'b0);
        chk("R9 rx restart", rx_restart, 1'b1);
        chk("R8 rx commit", rx_list_addr, 32'h1234beef);
        step(1, 3'd3, 16'h5678, 5'b0);
        chk("R9 no restart when valid", rx_restart, 1'b0);
        step(1, 3'd4, 16'h0100, 5'b0);
        step(1, 3'd5, 16'h0002, 5'b01000);
        chk("R10 set beats commit", rd_data[4], 1'b1);
        chk("R9 tx restart", tx_restart, 1'b1);

        // R11: vector and unused offsets
        step(1, 3'd1, 16'h00a5, 5'b0);
        @(negedge clk); rd_addr = 3'd1; #1;
        chk("R11 vector readback", rd_data, 16'h00a5);
        rd_addr = 3'd6; #1;
        chk("R11 unused offset", rd_data, 16'h0);
        rd_addr = 3'd3; #1;
        chk("R8 high readback", rd_data, 16'h5678);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] s;
            logic [2:0] a;
            for (int k = 0; k < 5; k++) s[k] = ($urandom % 6) == 0;
            a = 3'($urandom % 8);
            if (a > 3'd5 && ($urandom % 2)) a = 3'd0;
            step(($urandom % 3) != 0, a, 16'($urandom), s);
        end
        idle();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule